// File: doc/BRIEF.md
# Iterated Modular Squaring Engine

The engine takes a starting value x, an odd modulus N and an iteration count t, and squares the running value modulo N t times in a row. After the last pass it holds h = x^(2^t) mod N. Each squaring result goes straight back in as the next input, with no write-back from outside. Every completed squaring is announced by a one-cycle `valid` pulse on the result port. The result stays unchanged until the next squaring finishes, so a consumer can take it on the edge after the pulse.

Division is never performed. While loading, the engine fills a table whose entry i holds 2^(W+i) mod N. It builds these entries by repeated doubling, each doubling followed by a conditional subtraction of N. A squaring forms the full 2W-bit product and reduces its lower half with one conditional subtraction. It then walks the upper half SEG bits per cycle. In each of those cycles it adds the table entries selected by the set bits and brings the sum back below N with SEG chained conditional subtractions. The width W is a parameter: small values are used for simulation and 1024 is the target.

Top module: `msq_engine`

## Requirements
- R1: A `start` pulse while the engine is idle or done captures `x_in`, `n_in` and `t_in`, and `busy` is high from the next cycle on. N must be odd with bit W-1 set, and x must be below N.
- R2: After a start, 2W-1 cycles fill the residue table. During those cycles `busy` is high and no `valid` pulse occurs. The first `valid` appears 2W+W/SEG cycles after the edge that sampled `start`.
- R3: The k-th `valid` pulse after a start presents `sq_out` = x^(2^k) mod N.
- R4: `valid` is high for exactly one cycle per squaring, and consecutive pulses are W/SEG+1 cycles apart.
- R5: `sq_out` holds its value on the clock edge that follows a `valid` pulse, and at every other point until the next squaring completes.
- R6: After exactly t pulses, `done` goes high and `busy` goes low in the same cycle as the last pulse. `sq_out` then holds x^(2^t) mod N, and no further pulses occur.
- R7: With t = 0, `done` rises 2W-1 cycles after the start edge, no `valid` pulse occurs, and `sq_out` equals x.
- R8: `start` is ignored while `busy` is high. The running computation and its results are unaffected.
- R9: Every result is canonical (below N). This includes the edge inputs x = 0, x = 1 and x = N-1.
- R10: While `rst_n` is held low, and after it is released, `sq_out` is 0 and `valid`, `busy` and `done` are 0 until a start arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Load strobe for x, N and t |
| x_in | input | W | Starting value, below N |
| n_in | input | W | Odd modulus with bit W-1 set |
| t_in | input | CW | Number of squarings |
| sq_out | output | W | Running / final result |
| valid | output | 1 | One-cycle pulse per completed squaring |
| busy | output | 1 | Table fill or squaring in progress |
| done | output | 1 | All t squarings finished, result held |

## Verification
The bench sweeps fixed and random moduli, including the smallest allowed modulus 2^(W-1)+1 and one just below 2^W. It tries x = 0, 1, 2 and N-1, t = 0, 1 and longer runs, and checks every pulse against wide arithmetic. A table entry built with the wrong bit weight, or a missing conditional subtraction, shows up as a wrong or non-canonical value. The N-1 case squares to 1 and catches a reduction that leaves a value of N or more. Exact first-pulse latency, pulse spacing, result hold on the edge after a pulse, and the t = 0 path expose an off-by-one in the iteration counter or the fill length. A start poked mid-fill, if it were not ignored, would change the results.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUILD = 3'd1,
    ST_MUL   = 3'd2,
    ST_FOLD  = 3'd3,
    ST_DONE  = 3'd4
  } msq_state_t;
endpackage

// File: rtl/msq_rst_sync.sv
module msq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= 2'b00;
    else         sr_q <= {sr_q[0], 1'b1};
  end

  assign srst_n = sr_q[1];
endmodule

// File: rtl/msq_residue_table.sv
// Builds entry i = 2^(W+i) mod N by doubling, then serves SEG entries per read.
module msq_residue_table #(
  parameter int W   = 64,
  parameter int SEG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [W-1:0]               modulus,
  input  logic [$clog2(W/SEG)-1:0]   rd_idx,
  output logic [SEG*W-1:0]           rd_row,
  output logic                       ready
);
  localparam int NSEG = W / SEG;
  localparam int IW   = $clog2(NSEG);
  localparam int SW   = $clog2(SEG);
  localparam int AW   = $clog2(W);
  localparam int CNTW = $clog2(2 * W);

  logic            active_q, active_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [W-1:0]    v_q, v_d;
  logic [W:0]      twice, minus_n;
  logic [W-1:0]    v_dbl;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [W-1:0]    mem [W];

  // one doubling step with a single conditional subtract (v < N keeps 2v < 2N)
  always_comb begin
    twice   = {v_q, 1'b0};
    minus_n = twice - {1'b0, modulus};
    v_dbl   = (twice >= {1'b0, modulus}) ? minus_n[W-1:0] : twice[W-1:0];
  end

  assign wr_en   = active_q && (cnt_q >= CNTW'(W - 1));
  assign wr_addr = AW'(cnt_q - CNTW'(W - 1));
  assign ready   = active_q && (cnt_q == CNTW'(2 * W - 2));

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    v_d      = v_q;
    if (go) begin
      active_d = 1'b1;
      cnt_d    = '0;
      v_d      = W'(1);
    end else if (active_q) begin
      cnt_d = cnt_q + CNTW'(1);
      v_d   = v_dbl;
      if (ready) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      v_q      <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      v_q      <= v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= v_dbl;
  end

  for (genvar s = 0; s < SEG; s++) begin : g_rd
    localparam logic [SW-1:0] SOFF = SW'(s);
    assign rd_row[s*W +: W] = mem[{rd_idx, SOFF}];
  end

  // R2: the doubling register stays a residue throughout the fill
  a_r2_fill_residue: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (v_q < modulus));

  // R2: the fill finishes and releases the builder
  a_r2_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !go) |=> !active_q);

  if (IW + SW != AW) begin : g_bad_cfg
    initial $error("SEG must be a power of two >= 2 dividing W");
  end
endmodule

// File: rtl/msq_fold_step.sv
// acc + sum of selected table entries, then SEG conditional subtracts -> < N.
module msq_fold_step #(
  parameter int W   = 64,
  parameter int SEG = 4
) (
  input  logic [W-1:0]     acc_in,
  input  logic [SEG-1:0]   bits,
  input  logic [SEG*W-1:0] row,
  input  logic [W-1:0]     modulus,
  output logic [W-1:0]     acc_out
);
  localparam int XW = W + $clog2(SEG + 1) + 1;

  logic [XW-1:0] sum;

  always_comb begin
    sum = XW'(acc_in);
    for (int s = 0; s < SEG; s++) begin
      if (bits[s]) sum = sum + XW'(row[s*W +: W]);
    end
    for (int k = 0; k < SEG; k++) begin
      if (sum >= XW'(modulus)) sum = sum - XW'(modulus);
    end
    acc_out = sum[W-1:0];
  end
endmodule

// File: rtl/msq_engine.sv
module msq_engine #(
  parameter int W   = 64,
  parameter int SEG = 4,
  parameter int CW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  n_in,
  input  logic [CW-1:0] t_in,
  output logic [W-1:0]  sq_out,
  output logic          valid,
  output logic          busy,
  output logic          done
);
  import msq_pkg::*;

  localparam int NSEG = W / SEG;
  localparam int IW   = $clog2(NSEG);

  logic          rst_i_n;
  msq_state_t    state_q, state_d;
  logic [W-1:0]  val_q, val_d;
  logic [W-1:0]  mod_q, mod_d;
  logic [CW-1:0] left_q, left_d;
  logic [W-1:0]  hi_q, hi_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          valid_q, valid_d;

  logic [2*W-1:0]   prod;
  logic [W-1:0]     lo_red;
  logic [SEG*W-1:0] row;
  logic [W-1:0]     fold_out;
  logic             tbl_ready;
  logic             accept;
  logic             last_seg;

  msq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i_n)
  );

  assign accept   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign last_seg = (idx_q == IW'(NSEG - 1));

  msq_residue_table #(.W(W), .SEG(SEG)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .go      (accept),
    .modulus (mod_q),
    .rd_idx  (idx_q),
    .rd_row  (row),
    .ready   (tbl_ready)
  );

  msq_fold_step #(.W(W), .SEG(SEG)) u_fold (
    .acc_in  (acc_q),
    .bits    (hi_q[SEG-1:0]),
    .row     (row),
    .modulus (mod_q),
    .acc_out (fold_out)
  );

  // full square; the lower half is below 2^W < 2N, so one subtract suffices
  always_comb begin
    prod   = {{W{1'b0}}, val_q} * {{W{1'b0}}, val_q};
    lo_red = (prod[W-1:0] >= mod_q) ? (prod[W-1:0] - mod_q) : prod[W-1:0];
  end

  always_comb begin
    state_d = state_q;
    val_d   = val_q;
    mod_d   = mod_q;
    left_d  = left_q;
    hi_d    = hi_q;
    acc_d   = acc_q;
    idx_d   = idx_q;
    valid_d = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_BUILD;
          val_d   = x_in;
          mod_d   = n_in;
          left_d  = t_in;
        end
      end
      ST_BUILD: begin
        if (tbl_ready) state_d = (left_q == '0) ? ST_DONE : ST_MUL;
      end
      ST_MUL: begin
        acc_d   = lo_red;
        hi_d    = prod[2*W-1:W];
        idx_d   = '0;
        state_d = ST_FOLD;
      end
      ST_FOLD: begin
        acc_d = fold_out;
        hi_d  = hi_q >> SEG;
        idx_d = idx_q + IW'(1);
        if (last_seg) begin
          val_d   = fold_out;
          valid_d = 1'b1;
          left_d  = left_q - CW'(1);
          state_d = (left_q == CW'(1)) ? ST_DONE : ST_MUL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
      mod_q   <= '0;
      left_q  <= '0;
      hi_q    <= '0;
      acc_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      val_q   <= val_d;
      mod_q   <= mod_d;
      left_q  <= left_d;
      hi_q    <= hi_d;
      acc_q   <= acc_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign sq_out = val_q;
  assign valid  = valid_q;
  assign busy   = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done   = (state_q == ST_DONE);

  // R4: a completion pulse lasts one cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |=> !valid_q);

  // R9: results leave the engine canonical
  a_r9_result_canonical: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |-> (val_q < mod_q));

  // R9: the running accumulator stays a residue between fold steps
  a_r9_acc_canonical: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_FOLD) |-> (acc_q < mod_q));

  // R5: result held across the edge after a pulse
  a_r5_hold_after_valid: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |=> $stable(val_q));

  // R2: no completion pulse while the table fills
  a_r2_quiet_fill: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_BUILD) |-> !valid_q);

  // R6: once done, the result is frozen until a new start
  a_r6_done_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !start) |=> ($stable(val_q) && !valid_q));

  // R8: a start during a run does not reload the modulus or count
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && start) |=> ($stable(mod_q) && (left_q <= $past(left_q))));
endmodule

// File: tb/msq_engine_test.sv
module msq_engine_test;
  localparam int W      = 64;
  localparam int SEG    = 4;
  localparam int CW     = 32;
  localparam int NSEG   = W / SEG;
  localparam int FILL   = 2 * W - 1;
  localparam int FIRST  = 2 * W + NSEG;
  localparam int PERIOD = NSEG + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  x_in, n_in;
  logic [CW-1:0] t_in;
  logic [W-1:0]  sq_out;
  logic          valid, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  msq_engine #(.W(W), .SEG(SEG), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .n_in(n_in),
    .t_in(t_in), .sq_out(sq_out), .valid(valid), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sqmod(input logic [W-1:0] a, input logic [W-1:0] n);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, a};
    return W'(p % {{W{1'b0}}, n});
  endfunction

  task automatic run_case(input logic [W-1:0] x, input logic [W-1:0] n,
                          input int t, input bit poke);
    logic [W-1:0] exp, held;
    int k, cyc, last;
    bit fin;
    exp = x; k = 0; cyc = 0; last = 0; fin = 0;
    @(negedge clk);
    x_in = x; n_in = n; t_in = CW'(t); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", W'(busy), W'(1));
    while (!fin && cyc < FIRST + PERIOD * (t + 2)) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (start) start = 1'b0;
      if (cyc == 5)
        chk(busy === 1'b1 && valid === 1'b0, "R2", "busy during fill",
            W'({busy, valid}), W'(2));
      if (valid === 1'b1) begin
        k++;
        exp = sqmod(exp, n);
        chk(sq_out === exp, "R3", "squaring result", sq_out, exp);
        chk(sq_out < n, "R9", "result below N", sq_out, n);
        if (k == 1) chk(cyc == FIRST, "R2", "first pulse latency", W'(cyc), W'(FIRST));
        else chk(cyc - last == PERIOD, "R4", "pulse spacing", W'(cyc - last), W'(PERIOD));
        last = cyc;
        held = sq_out;
        if (done !== 1'b1) begin
          @(posedge clk);
          @(negedge clk);
          cyc++;
          chk(valid === 1'b0, "R4", "pulse width", W'(valid), W'(0));
          chk(sq_out === held, "R5", "hold after pulse", sq_out, held);
        end
      end
      if (poke && cyc == 10) begin
        x_in = ~x; n_in = n ^ 64'h10; t_in = CW'(1); start = 1'b1;  // R8 poke
      end
      if (done === 1'b1) fin = 1;
    end
    chk(k == t, "R6", "pulse count", W'(k), W'(t));
    chk(done === 1'b1 && busy === 1'b0, "R6", "done/busy at end", W'({done, busy}), W'(2));
    chk(sq_out === exp, "R6", "final value", sq_out, exp);
    if (t == 0) begin
      chk(cyc == FILL, "R7", "t=0 done latency", W'(cyc), W'(FILL));
      chk(sq_out === x, "R7", "t=0 keeps x", sq_out, x);
    end
    held = sq_out;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(valid === 1'b0 && sq_out === held, "R6", "quiet after done",
          sq_out, held);
    end
  endtask

  initial begin
    logic [W-1:0] n, x;
    rst_n = 1'b0; start = 1'b0; x_in = '0; n_in = '0; t_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sq_out === '0 && {valid, busy, done} === 3'b000, "R10", "state in reset",
        sq_out, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sq_out === '0 && {valid, busy, done} === 3'b000, "R10", "state after reset",
        W'({valid, busy, done}), '0);

    for (int m = 0; m < 8; m++) begin
      if (m == 0)      n = 64'hFFFF_FFFF_FFFF_FFC5;
      else if (m == 1) n = 64'h8000_0000_0000_0001;
      else             n = {1'b1, 31'($urandom), $urandom} | 64'h1;
      run_case('0, n, 3, 1'b0);            // R9 x = 0
      run_case(64'd1, n, 2, 1'b0);         // R9 x = 1
      run_case(64'd2, n, 7, 1'b0);         // R3 powers of two
      run_case(n - 64'd1, n, 2, 1'b0);     // R9 x = N-1 -> 1
      x = {$urandom, $urandom} % n;
      run_case(x, n, 1, 1'b0);             // R6 single squaring
      x = {$urandom, $urandom} % n;
      run_case(x, n, 12, (m % 2) == 0);    // R3 long run, R8 poke
    end
    run_case(64'h1234_5678_9ABC_DEF1, 64'hFFFF_FFFF_FFFF_FFC5, 0, 1'b0);  // R7
    run_case(64'h0000_0000_0000_0003, 64'h8000_0000_0000_0001, 0, 1'b1);  // R7, R8

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule